// File: doc/BRIEF.md
# Host-to-Processor Triple Mailbox

This block sits between a host and an attached processor and carries words both ways through three mailboxes. Two single-entry boxes carry data upward: a data box and a notify box, both written by the processor and read by the host. A four-entry queue carries words downward: the host writes it and the processor pops it in arrival order.

The block exposes a packed 24-bit occupancy word. The host makes one access per request beat and receives a registered response that says whether the access took effect. An access that cannot take effect is a no-op: a read of an empty box, or a write to a full queue. The host is never stalled. Instead, the block arms a wake-up enable, so the host can sleep until data or space appears.

The processor side sees channel counts: the space left in each upward box and the fill level of the downward queue. It also receives one-cycle event pulses for an event unit. A redundant free counter runs beside the queue level. A sticky error flag reports any moment when the two disagree.

Top module: `tri_mailbox`

## Requirements
- R1: After reset, `stat_word` is 24'h000400, `chan_out_cnt` and `chan_irq_cnt` are 1, `chan_in_cnt` is 0, and all response, event, enable, status and wake outputs are 0.
- R1 (layout): `stat_word` bits [7:0] hold the data-box entry count (0 or 1), bits [15:8] hold the free downward-queue slots, and bits [23:16] hold the notify-box entry count (0 or 1).
- R1 (timing): every host request (`host_req_valid`=1) produces `host_rsp_valid`=1 on the next edge.
- R2: A host read of the data box (op 0) succeeds only when field [7:0] is nonzero. On success it returns the word, clears the field, sets `chan_out_cnt` to 1 and pulses `ev_out_free`. On failure it returns `host_rsp_ok`=0 with rdata 0.
- R3: A processor write to an empty upward box stores the word, sets its field to 1 and its channel count to 0. A write to a full box is ignored, and the stored word and field are kept.
- R4: A host read of the notify box (op 1) behaves as in R2, using field [23:16], `chan_irq_cnt` and `ev_irq_free`. When the box is empty, the read also sets `wake_en_mbox`.
- R5: A host write to the downward queue (op 2) succeeds only when field [15:8] is nonzero. On success it stores the word, decrements the free field, increments `chan_in_cnt` and pulses `ev_in_written`. On failure the word is dropped, `host_rsp_ok` is 0, and `wake_en_space` is set.
- R6: The free field plus `chan_in_cnt` always equals the queue depth, and `sync_err` stays 0.
- R7: A processor pop returns entries in write order. `proc_in_valid` and `proc_in_rdata` appear one edge after the pop. A pop of an empty queue is ignored. A successful pop raises the free field by one and sets `wake_st_space`.
- R8: A poll (op 3) always has `host_rsp_ok`=1. It reports readable when the notify box is full and writable when the free field is nonzero. When not readable, the poll clears `wake_st_mbox` and sets `wake_en_mbox`. When not writable, it clears `wake_st_space` and sets `wake_en_space`. If a status set and a poll clear happen in the same cycle, the set wins.
- R9: A successful processor write to the notify box sets `wake_st_mbox`. `host_wake` is high whenever a status bit and its enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req_valid | input | 1 | Host request this cycle |
| host_req_op | input | 2 | 0 read data box, 1 read notify box, 2 write queue, 3 poll |
| host_req_wdata | input | DATA_W | Word for a queue write |
| host_rsp_valid | output | 1 | Response for last cycle's request |
| host_rsp_ok | output | 1 | Access took effect |
| host_rsp_rdata | output | DATA_W | Word read, zero otherwise |
| host_rsp_readable | output | 1 | Poll result: notify box full |
| host_rsp_writable | output | 1 | Poll result: queue has space |
| proc_out_wr | input | 1 | Processor writes the data box |
| proc_out_wdata | input | DATA_W | Word for the data box |
| proc_irq_wr | input | 1 | Processor writes the notify box |
| proc_irq_wdata | input | DATA_W | Word for the notify box |
| proc_in_pop | input | 1 | Processor pops the queue |
| proc_in_valid | output | 1 | Popped word present |
| proc_in_rdata | output | DATA_W | Popped word |
| chan_out_cnt | output | CNT_W | Space in the data box |
| chan_irq_cnt | output | CNT_W | Space in the notify box |
| chan_in_cnt | output | CNT_W | Queue fill level |
| ev_out_free | output | 1 | Data box emptied by host |
| ev_irq_free | output | 1 | Notify box emptied by host |
| ev_in_written | output | 1 | Queue written by host |
| stat_word | output | 3*CNT_W | Packed occupancy word |
| wake_en_mbox | output | 1 | Notify wake-up enable |
| wake_en_space | output | 1 | Space wake-up enable |
| wake_st_mbox | output | 1 | Notify wake-up pending |
| wake_st_space | output | 1 | Space wake-up pending |
| host_wake | output | 1 | Wake-up request to host |
| sync_err | output | 1 | Sticky free/level disagreement |

## Verification
The following results are due one edge after the request or processor strobe that causes them, because they are all registered:
- host responses and event pulses;
- channel counts and the occupancy word;
- wake enables and status;
- popped data.

`host_wake` is decoded from registers, so it moves on that same edge. The bench drives every stimulus just after a falling edge and lets one rising edge pass. It compares at the next falling edge against a model that advances from the pre-edge state. No check therefore straddles a second register stage or races the edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    HOP_RD_OUT = 2'd0,
    HOP_RD_IRQ = 2'd1,
    HOP_WR_IN  = 2'd2,
    HOP_POLL   = 2'd3
  } host_op_e;
endpackage

// File: rtl/mbx_single.sv
// One-word upward mailbox: processor fills, host drains.
module mbx_single #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              put,
  input  logic [DATA_W-1:0] put_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] word,
  output logic              put_done,
  output logic              take_done
);
  assign put_done  = put && !full;
  assign take_done = take && full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      word <= '0;
    end else if (put_done) begin
      full <= 1'b1;
      word <= put_data;
    end else if (take_done) begin
      full <= 1'b0;
    end
  end

  // R2: a successful host read leaves the box empty
  a_r2_take_empties: assert property (@(posedge clk) disable iff (rst)
    take_done |=> !full);

  // R3: processor write to a full box keeps the stored word
  a_r3_full_keeps_word: assert property (@(posedge clk) disable iff (rst)
    (full && put && !take) |=> (full && word == $past(word)));
endmodule

// File: rtl/mbx_inq.sv
// Downward queue: circular buffer with a level and an independent free counter.
module mbx_inq #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic              push_done,
  output logic              pop_done,
  output logic [CNT_W-1:0]  level,
  output logic [CNT_W-1:0]  free_cnt,
  output logic              head_valid,
  output logic [DATA_W-1:0] head_data,
  output logic              mismatch
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0]    LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
  localparam logic [CNT_W:0]   SUM_REF  = (CNT_W+1)'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     rd_ptr, wr_ptr;
  logic [CNT_W:0]    sum;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign push_done = push && (free_cnt != '0);
  assign pop_done  = pop && (level != '0);
  assign sum       = {1'b0, level} + {1'b0, free_cnt};

  // storage: single write port, registered read
  always_ff @(posedge clk) begin
    if (push_done) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (pop_done) head_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr     <= '0;
      wr_ptr     <= '0;
      level      <= '0;
      free_cnt   <= FULL_LVL;
      head_valid <= 1'b0;
      mismatch   <= 1'b0;
    end else begin
      head_valid <= pop_done;
      mismatch   <= mismatch | (sum != SUM_REF);
      if (push_done) wr_ptr <= bump(wr_ptr);
      if (pop_done)  rd_ptr <= bump(rd_ptr);
      case ({push_done, pop_done})
        2'b10: begin
          level    <= level + 1'b1;
          free_cnt <= free_cnt - 1'b1;
        end
        2'b01: begin
          level    <= level - 1'b1;
          free_cnt <= free_cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R6: free counter and level stay locked together
  a_r6_free_locked: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, level} + {1'b0, free_cnt}) == SUM_REF);

  // R5: write into a full queue leaves the level alone
  a_r5_full_drop: assert property (@(posedge clk) disable iff (rst)
    (push && free_cnt == '0 && !pop) |=> (level == $past(level)));

  // R5: no overflow
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    level <= FULL_LVL);

  // R7: pop of an empty queue yields nothing
  a_r7_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (pop && level == '0) |=> !head_valid);
endmodule

// File: rtl/mbx_wake.sv
// Wake-up enable/status pairs: index 0 notify box, index 1 queue space.
module mbx_wake #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set_en,
  input  logic [NCH-1:0] set_st,
  input  logic [NCH-1:0] clr_st,
  output logic [NCH-1:0] en,
  output logic [NCH-1:0] st,
  output logic           wake
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic en_q, st_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        en_q <= 1'b0;
        st_q <= 1'b0;
      end else begin
        if (set_en[i]) en_q <= 1'b1;
        if (set_st[i])      st_q <= 1'b1;
        else if (clr_st[i]) st_q <= 1'b0;
      end
    end
    assign en[i] = en_q;
    assign st[i] = st_q;

    // R8: a status set wins over a same-cycle poll clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
      set_st[i] |=> st[i]);
  end

  assign wake = |(en & st);
endmodule

// File: rtl/tri_mailbox.sv
module tri_mailbox #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 host_req_valid,
  input  logic [1:0]           host_req_op,
  input  logic [DATA_W-1:0]    host_req_wdata,
  output logic                 host_rsp_valid,
  output logic                 host_rsp_ok,
  output logic [DATA_W-1:0]    host_rsp_rdata,
  output logic                 host_rsp_readable,
  output logic                 host_rsp_writable,
  input  logic                 proc_out_wr,
  input  logic [DATA_W-1:0]    proc_out_wdata,
  input  logic                 proc_irq_wr,
  input  logic [DATA_W-1:0]    proc_irq_wdata,
  input  logic                 proc_in_pop,
  output logic                 proc_in_valid,
  output logic [DATA_W-1:0]    proc_in_rdata,
  output logic [CNT_W-1:0]     chan_out_cnt,
  output logic [CNT_W-1:0]     chan_irq_cnt,
  output logic [CNT_W-1:0]     chan_in_cnt,
  output logic                 ev_out_free,
  output logic                 ev_irq_free,
  output logic                 ev_in_written,
  output logic [3*CNT_W-1:0]   stat_word,
  output logic                 wake_en_mbox,
  output logic                 wake_en_space,
  output logic                 wake_st_mbox,
  output logic                 wake_st_space,
  output logic                 host_wake,
  output logic                 sync_err
);
  import mbx_pkg::*;

  host_op_e op;
  logic rd_out, rd_irq, wr_in, poll;
  logic out_full, out_put_done, out_take_done;
  logic irq_full, irq_put_done, irq_take_done;
  logic [DATA_W-1:0] out_word, irq_word;
  logic push_done, pop_done;
  logic [CNT_W-1:0] free_cnt;
  logic writable;
  logic [1:0] w_set_en, w_set_st, w_clr_st, w_en, w_st;

  assign op     = host_op_e'(host_req_op);
  assign rd_out = host_req_valid && (op == HOP_RD_OUT);
  assign rd_irq = host_req_valid && (op == HOP_RD_IRQ);
  assign wr_in  = host_req_valid && (op == HOP_WR_IN);
  assign poll   = host_req_valid && (op == HOP_POLL);

  mbx_single #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .put(proc_out_wr), .put_data(proc_out_wdata),
    .take(rd_out), .full(out_full), .word(out_word),
    .put_done(out_put_done), .take_done(out_take_done));

  mbx_single #(.DATA_W(DATA_W)) u_irq (
    .clk(clk), .rst(rst), .put(proc_irq_wr), .put_data(proc_irq_wdata),
    .take(rd_irq), .full(irq_full), .word(irq_word),
    .put_done(irq_put_done), .take_done(irq_take_done));

  mbx_inq #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_inq (
    .clk(clk), .rst(rst), .push(wr_in), .push_data(host_req_wdata),
    .pop(proc_in_pop), .push_done(push_done), .pop_done(pop_done),
    .level(chan_in_cnt), .free_cnt(free_cnt),
    .head_valid(proc_in_valid), .head_data(proc_in_rdata),
    .mismatch(sync_err));

  assign writable = (free_cnt != '0);

  // index 0: notify box, index 1: queue space
  assign w_set_en[0] = (rd_irq || poll) && !irq_full;
  assign w_clr_st[0] = poll && !irq_full;
  assign w_set_st[0] = irq_put_done;
  assign w_set_en[1] = (wr_in || poll) && !writable;
  assign w_clr_st[1] = poll && !writable;
  assign w_set_st[1] = pop_done;

  mbx_wake #(.NCH(2)) u_wake (
    .clk(clk), .rst(rst), .set_en(w_set_en), .set_st(w_set_st),
    .clr_st(w_clr_st), .en(w_en), .st(w_st), .wake(host_wake));

  assign wake_en_mbox  = w_en[0];
  assign wake_en_space = w_en[1];
  assign wake_st_mbox  = w_st[0];
  assign wake_st_space = w_st[1];

  assign chan_out_cnt = CNT_W'(!out_full);
  assign chan_irq_cnt = CNT_W'(!irq_full);
  assign stat_word    = {CNT_W'(irq_full), free_cnt, CNT_W'(out_full)};

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rsp_valid    <= 1'b0;
      host_rsp_ok       <= 1'b0;
      host_rsp_rdata    <= '0;
      host_rsp_readable <= 1'b0;
      host_rsp_writable <= 1'b0;
      ev_out_free       <= 1'b0;
      ev_irq_free       <= 1'b0;
      ev_in_written     <= 1'b0;
    end else begin
      host_rsp_valid    <= host_req_valid;
      host_rsp_ok       <= out_take_done || irq_take_done || push_done || poll;
      host_rsp_rdata    <= out_take_done ? out_word :
                           irq_take_done ? irq_word : '0;
      host_rsp_readable <= poll && irq_full;
      host_rsp_writable <= poll && writable;
      ev_out_free       <= out_take_done;
      ev_irq_free       <= irq_take_done;
      ev_in_written     <= push_done;
    end
  end

  // R1: every request is answered on the next edge
  a_r1_rsp_next: assert property (@(posedge clk) disable iff (rst)
    host_req_valid |=> host_rsp_valid);

  // R2: failed accesses return zero data
  a_r2_fail_zero: assert property (@(posedge clk) disable iff (rst)
    (host_rsp_valid && !host_rsp_ok) |-> (host_rsp_rdata == '0));

  // R4: empty notify read arms the wake-up enable
  a_r4_empty_arms: assert property (@(posedge clk) disable iff (rst)
    (host_req_valid && host_req_op == 2'd1 && stat_word[3*CNT_W-1:2*CNT_W] == '0)
      |=> wake_en_mbox);

  // R5: failed queue write arms the space enable
  a_r5_full_arms: assert property (@(posedge clk) disable iff (rst)
    (host_req_valid && host_req_op == 2'd2 && stat_word[2*CNT_W-1:CNT_W] == '0)
      |=> (wake_en_space && !ev_in_written));

  // R9: notify write raises the pending status
  a_r9_notify_sets: assert property (@(posedge clk) disable iff (rst)
    (proc_irq_wr && chan_irq_cnt != '0) |=> wake_st_mbox);
endmodule

// File: tb/sim_tri_mailbox.sv
module sim_tri_mailbox;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 4;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rst;
  logic host_req_valid;
  logic [1:0] host_req_op;
  logic [DATA_W-1:0] host_req_wdata;
  logic host_rsp_valid, host_rsp_ok, host_rsp_readable, host_rsp_writable;
  logic [DATA_W-1:0] host_rsp_rdata;
  logic proc_out_wr, proc_irq_wr, proc_in_pop, proc_in_valid;
  logic [DATA_W-1:0] proc_out_wdata, proc_irq_wdata, proc_in_rdata;
  logic [CNT_W-1:0] chan_out_cnt, chan_irq_cnt, chan_in_cnt;
  logic ev_out_free, ev_irq_free, ev_in_written;
  logic [3*CNT_W-1:0] stat_word;
  logic wake_en_mbox, wake_en_space, wake_st_mbox, wake_st_space, host_wake, sync_err;

  always #(CLK_P/2) clk = ~clk;

  tri_mailbox #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (.*);

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  // bench model
  bit m_out_full, m_irq_full, m_en_mb, m_en_sp, m_st_mb, m_st_sp;
  logic [DATA_W-1:0] m_out_word, m_irq_word;
  logic [DATA_W-1:0] m_q [DEPTH];
  int m_cnt;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_stat();
    return {8'(m_irq_full), 8'(DEPTH - m_cnt), 8'(m_out_full)};
  endfunction

  task automatic step(input bit hv, input logic [1:0] op, input logic [31:0] wd,
                      input bit pow, input logic [31:0] powd,
                      input bit piw, input logic [31:0] piwd, input bit pop);
    bit out_take, irq_take, push, popd, is_poll, out_put, irq_put, ok;
    int free;
    logic [31:0] rd, pdata;
    string t;
    host_req_valid = hv; host_req_op = op; host_req_wdata = wd;
    proc_out_wr = pow; proc_out_wdata = powd;
    proc_irq_wr = piw; proc_irq_wdata = piwd;
    proc_in_pop = pop;
    free     = DEPTH - m_cnt;
    out_take = hv && op == 2'd0 && m_out_full;
    irq_take = hv && op == 2'd1 && m_irq_full;
    push     = hv && op == 2'd2 && free != 0;
    is_poll  = hv && op == 2'd3;
    popd     = pop && m_cnt != 0;
    out_put  = pow && !m_out_full;
    irq_put  = piw && !m_irq_full;
    ok       = out_take || irq_take || push || is_poll;
    rd       = out_take ? m_out_word : irq_take ? m_irq_word : 32'd0;
    pdata    = m_q[0];
    t = (op == 2'd0) ? "R2" : (op == 2'd1) ? "R4" : (op == 2'd2) ? "R5" : "R8";
    @(posedge clk);
    @(negedge clk);
    host_req_valid = 0; proc_out_wr = 0; proc_irq_wr = 0; proc_in_pop = 0;
    // expected readable/writable from pre-state
    chk("R8", "readable", 32'(host_rsp_readable), 32'(is_poll && m_irq_full));
    chk("R8", "writable", 32'(host_rsp_writable), 32'(is_poll && free != 0));
    // model update
    if (hv && (op == 2'd1 || op == 2'd3) && !m_irq_full) m_en_mb = 1;
    if (hv && (op == 2'd2 || op == 2'd3) && free == 0)   m_en_sp = 1;
    if (irq_put) m_st_mb = 1; else if (is_poll && !m_irq_full) m_st_mb = 0;
    if (popd)    m_st_sp = 1; else if (is_poll && free == 0)   m_st_sp = 0;
    if (out_put) begin m_out_full = 1; m_out_word = powd; end
    else if (out_take) m_out_full = 0;
    if (irq_put) begin m_irq_full = 1; m_irq_word = piwd; end
    else if (irq_take) m_irq_full = 0;
    if (popd) begin
      for (int i = 0; i < DEPTH - 1; i++) m_q[i] = m_q[i+1];
      m_cnt--;
    end
    if (push) begin m_q[m_cnt] = wd; m_cnt++; end
    // compare
    chk("R1", "rsp_valid", 32'(host_rsp_valid), 32'(hv));
    chk(t, "rsp_ok", 32'(host_rsp_ok), 32'(hv && ok));
    chk(t, "rsp_rdata", host_rsp_rdata, rd);
    chk("R1", "stat_word", 32'(stat_word), 32'(exp_stat()));
    chk("R3", "out_field", 32'(stat_word[7:0]), 32'(m_out_full));
    chk("R2", "chan_out_cnt", 32'(chan_out_cnt), 32'(!m_out_full));
    chk("R4", "chan_irq_cnt", 32'(chan_irq_cnt), 32'(!m_irq_full));
    chk("R5", "chan_in_cnt", 32'(chan_in_cnt), 32'(m_cnt));
    chk("R2", "ev_out_free", 32'(ev_out_free), 32'(out_take));
    chk("R4", "ev_irq_free", 32'(ev_irq_free), 32'(irq_take));
    chk("R5", "ev_in_written", 32'(ev_in_written), 32'(push));
    chk("R7", "in_valid", 32'(proc_in_valid), 32'(popd));
    if (popd) chk("R7", "in_data", proc_in_rdata, pdata);
    chk("R8", "en_mbox", 32'(wake_en_mbox), 32'(m_en_mb));
    chk("R8", "en_space", 32'(wake_en_space), 32'(m_en_sp));
    chk("R9", "st_mbox", 32'(wake_st_mbox), 32'(m_st_mb));
    chk("R7", "st_space", 32'(wake_st_space), 32'(m_st_sp));
    chk("R9", "host_wake", 32'(host_wake),
        32'((m_st_mb && m_en_mb) || (m_st_sp && m_en_sp)));
    chk("R6", "sync_err", 32'(sync_err), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1; host_req_valid = 0; host_req_op = 0; host_req_wdata = 0;
    proc_out_wr = 0; proc_out_wdata = 0; proc_irq_wr = 0; proc_irq_wdata = 0;
    proc_in_pop = 0;
    m_out_full = 0; m_irq_full = 0; m_en_mb = 0; m_en_sp = 0; m_st_mb = 0; m_st_sp = 0;
    m_out_word = 0; m_irq_word = 0; m_cnt = 0;
    for (int i = 0; i < DEPTH; i++) m_q[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1", "reset stat_word", 32'(stat_word), 32'h000400);
    chk("R1", "reset rsp_valid", 32'(host_rsp_valid), 32'd0);
    chk("R1", "reset chan_out", 32'(chan_out_cnt), 32'd1);
    chk("R1", "reset chan_irq", 32'(chan_irq_cnt), 32'd1);
    chk("R1", "reset chan_in", 32'(chan_in_cnt), 32'd0);
    chk("R1", "reset wake", 32'(host_wake), 32'd0);

    // R2 empty read, then R3 fill, ignored overwrite, successful read
    step(1, 2'd0, 0, 0, 0, 0, 0, 0);
    step(0, 2'd0, 0, 1, 32'hAAAA_0001, 0, 0, 0);
    step(0, 2'd0, 0, 1, 32'hBBBB_0002, 0, 0, 0);
    step(1, 2'd0, 0, 0, 0, 0, 0, 0);
    // R4 empty notify read arms enable; R9 write then wake
    step(1, 2'd1, 0, 0, 0, 0, 0, 0);
    step(0, 2'd0, 0, 0, 0, 1, 32'hC0DE_0003, 0);
    step(1, 2'd3, 0, 0, 0, 0, 0, 0);
    step(1, 2'd1, 0, 0, 0, 0, 0, 0);
    // R5 fill queue and overfill
    for (int i = 0; i < DEPTH + 1; i++) step(1, 2'd2, 32'h1000 + i, 0, 0, 0, 0, 0);
    step(1, 2'd3, 0, 0, 0, 0, 0, 0);
    // R7 pop order, simultaneous push/pop, empty pop
    step(0, 2'd0, 0, 0, 0, 0, 0, 1);
    step(1, 2'd2, 32'h2000, 0, 0, 0, 0, 1);
    for (int i = 0; i < DEPTH + 1; i++) step(0, 2'd0, 0, 0, 0, 0, 0, 1);
    // R8 poll on empty box with same-cycle notify write (set wins)
    step(1, 2'd3, 0, 0, 0, 1, 32'h7777, 0);

    // random phases
    for (int n = 0; n < 3000; n++) begin
      int pp = (n < 1500) ? 15 : 50;
      step(($urandom % 4) != 0, 2'($urandom), $urandom,
           ($urandom % 10) < 3, $urandom, ($urandom % 10) < 2, $urandom,
           ($urandom % 100) < pp);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule